// File: doc/BRIEF.md
# Four-Mode Word Shifter

This block shifts a 32-bit word by 0 to 31 positions in one of four ways: logical right, arithmetic right, logical left, or rotate left. The result appears one clock after the request, together with a valid flag.

The shift distance is a 5-bit count that comes from one of two places: a count field carried in the instruction, or the low five bits of a count register. A nonzero field takes priority. A field of zero selects the register bits instead. Only whole 32-bit words are handled.

Top module: `word_shifter`

## Requirements
- R1: While reset is held and in the first cycle after it, `outValid` is 0 and `result` is 0.
- R2: Shift kind 2'b00 is logical right: `result` equals the operand shifted right by the count, with the vacated upper bits set to 0.
- R3: Shift kind 2'b01 is arithmetic right: the vacated upper bits take the operand's original bit 31.
- R4: Shift kind 2'b10 is logical left: the vacated lower bits are set to 0.
- R5: Shift kind 2'b11 rotates left: bits leaving at bit 31 re-enter at bit 0.
- R6: When `countField` is nonzero it is the count, and `countReg` has no effect on `result`.
- R7: When `countField` is zero, the count is `countReg[4:0]`, and `countReg[31:5]` has no effect.
- R8: An effective count of zero returns the operand unchanged, for every shift kind.
- R9: `outValid` in a cycle equals `inValid` in the previous cycle. `result` is loaded only on a cycle where `inValid` is 1, and holds its value otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| inValid | input | 1 | Request strobe |
| operand | input | 32 | Word to shift |
| shiftKind | input | 2 | 00 logical right, 01 arithmetic right, 10 left, 11 rotate left |
| countField | input | 5 | Count from the instruction; zero selects the register |
| countReg | input | 32 | Count register value; only bits 4:0 are used |
| outValid | output | 1 | Result valid, one cycle after the request |
| result | output | 32 | Registered shifted word |

## Verification
Count-source selection and the fill rule of the chosen shift kind both take effect in the same cycle. The bench provokes this by sending arithmetic right shifts and rotates of words with bit 31 set, with a zero field and upper junk bits in the count register, and also with a nonzero field alongside a conflicting register value. Each result is compared against a reference computed in the bench from the requirement text. Back-to-back requests followed by idle cycles show that each result lands exactly one cycle after its request, and that it then holds.

// File: rtl/shifter_pkg.sv
package shifter_pkg;
  localparam int DATA_W = 32;
  localparam int CNT_W  = $clog2(DATA_W);

  typedef enum logic [1:0] {
    SH_LSR = 2'b00,
    SH_ASR = 2'b01,
    SH_LSL = 2'b10,
    SH_ROL = 2'b11
  } shKind_e;

  typedef struct packed {
    logic             load;
    shKind_e          kind;
    logic [CNT_W-1:0] amount;
  } shStrobe_t;
endpackage

// File: rtl/shift_ctrl.sv
module shift_ctrl
  import shifter_pkg::*;
#(
  parameter int DW = DATA_W,
  parameter int CW = CNT_W
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          inValid,
  input  logic [1:0]    shiftKind,
  input  logic [CW-1:0] countField,
  input  logic [DW-1:0] countReg,
  output shStrobe_t     strobe,
  output logic          outValid
);
  logic fieldZero;

  always_comb begin
    fieldZero     = (countField == '0);
    strobe.load   = inValid;
    strobe.kind   = shKind_e'(shiftKind);
    strobe.amount = fieldZero ? countReg[CW-1:0] : countField;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) outValid <= 1'b0;
    else        outValid <= inValid;
  end

  // R9: valid follows request with one cycle of latency
  p_valid_rise_r9: assert property (@(posedge clk) disable iff (!rst_n)
    inValid |=> outValid);
  p_valid_idle_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !inValid |=> !outValid);
endmodule

// File: rtl/shift_datapath.sv
module shift_datapath
  import shifter_pkg::*;
#(
  parameter int DW = DATA_W,
  parameter int CW = CNT_W
) (
  input  logic          clk,
  input  logic          rst_n,
  input  shStrobe_t     strobe,
  input  logic [DW-1:0] operand,
  output logic [DW-1:0] result
);
  logic [DW-1:0] stg [0:CW];
  logic          signBit;

  assign signBit = operand[DW-1];
  assign stg[0]  = operand;

  for (genvar i = 0; i < CW; i++) begin : g_stage
    localparam int S = 1 << i;
    logic [DW-1:0] moved;
    always_comb begin
      unique case (strobe.kind)
        SH_LSR:  moved = {{S{1'b0}}, stg[i][DW-1:S]};
        SH_ASR:  moved = {{S{signBit}}, stg[i][DW-1:S]};
        SH_LSL:  moved = {stg[i][DW-1-S:0], {S{1'b0}}};
        default: moved = {stg[i][DW-1-S:0], stg[i][DW-1:DW-S]};
      endcase
    end
    assign stg[i+1] = strobe.amount[i] ? moved : stg[i];
  end

  always_ff @(posedge clk) begin
    if (!rst_n)           result <= '0;
    else if (strobe.load) result <= stg[CW];
  end

  // R8: zero count passes operand through
  p_zero_pass_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (strobe.load && strobe.amount == '0) |=> result == $past(operand));
  // R9: result holds without a request
  p_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !strobe.load |=> $stable(result));
  // R3: arithmetic right keeps a set sign bit
  p_sign_fill_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (strobe.load && strobe.kind == SH_ASR && operand[DW-1]) |=> result[DW-1]);
  // R4: left shift by nonzero count clears bit 0
  p_left_lsb_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (strobe.load && strobe.kind == SH_LSL && strobe.amount != '0) |=> !result[0]);
  // R2: logical right by nonzero count clears bit 31
  p_right_msb_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (strobe.load && strobe.kind == SH_LSR && strobe.amount != '0) |=> !result[DW-1]);
  // R5: rotate preserves population count
  p_rot_pop_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (strobe.load && strobe.kind == SH_ROL) |=> $countones(result) == $countones($past(operand)));
endmodule

// File: rtl/word_shifter.sv
module word_shifter
  import shifter_pkg::*;
#(
  parameter int DW = DATA_W,
  parameter int CW = CNT_W
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          inValid,
  input  logic [DW-1:0] operand,
  input  logic [1:0]    shiftKind,
  input  logic [CW-1:0] countField,
  input  logic [DW-1:0] countReg,
  output logic          outValid,
  output logic [DW-1:0] result
);
  shStrobe_t strobe;

  shift_ctrl #(.DW(DW), .CW(CW)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .inValid(inValid), .shiftKind(shiftKind),
    .countField(countField), .countReg(countReg), .strobe(strobe), .outValid(outValid)
  );

  shift_datapath #(.DW(DW), .CW(CW)) u_dp (
    .clk(clk), .rst_n(rst_n), .strobe(strobe), .operand(operand), .result(result)
  );
endmodule

// File: tb/test_word_shifter.sv
module test_word_shifter;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        inValid = 1'b0;
  logic [31:0] operand = '0;
  logic [1:0]  shiftKind = '0;
  logic [4:0]  countField = '0;
  logic [31:0] countReg = '0;
  logic        outValid;
  logic [31:0] result;
  int checks = 0;
  int failures = 0;

  always #4 clk = ~clk;

  word_shifter i_word_shifter (
    .clk(clk), .rst_n(rst_n), .inValid(inValid), .operand(operand),
    .shiftKind(shiftKind), .countField(countField), .countReg(countReg),
    .outValid(outValid), .result(result)
  );

  function automatic logic [31:0] refShift(logic [31:0] op, logic [1:0] k, int n);
    case (k)
      2'b00: return op >> n;
      2'b01: return 32'($signed(op) >>> n);
      2'b10: return op << n;
      default: return (n == 0) ? op : ((op << n) | (op >> (32 - n)));
    endcase
  endfunction

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic shot(string req, logic [31:0] op, logic [1:0] k, logic [4:0] f, logic [31:0] r);
    int n;
    n = (f != 0) ? int'(f) : int'(r[4:0]);
    @(negedge clk);
    operand = op; shiftKind = k; countField = f; countReg = r; inValid = 1'b1;
    @(negedge clk);
    inValid = 1'b0;
    check({req, " valid"}, {31'b0, outValid}, 32'd1);
    check(req, result, refShift(op, k, n));
  endtask

  task automatic t_reset();
    check("R1 valid", {31'b0, outValid}, 32'd0);
    check("R1 result", result, 32'd0);
  endtask

  task automatic t_kinds();
    shot("R2 lsr", 32'hF000_00F0, 2'b00, 5'd4, 32'd0);
    shot("R2 lsr31", 32'h8000_0000, 2'b00, 5'd31, 32'd0);
    shot("R3 asr neg", 32'h8000_1234, 2'b01, 5'd8, 32'd0);
    shot("R3 asr pos", 32'h7000_1234, 2'b01, 5'd8, 32'd0);
    shot("R4 lsl", 32'h0000_FFFF, 2'b10, 5'd20, 32'd0);
    shot("R5 rol", 32'h8000_0001, 2'b11, 5'd1, 32'd0);
    shot("R5 rol31", 32'hDEAD_BEEF, 2'b11, 5'd31, 32'd0);
  endtask

  task automatic t_source();
    shot("R6 field wins", 32'h1234_5678, 2'b00, 5'd8, 32'd3);
    shot("R7 reg count", 32'h8765_4321, 2'b01, 5'd0, 32'hFFFF_FFE5);
    shot("R7 reg rol", 32'hF000_000F, 2'b11, 5'd0, 32'h0000_0044);
  endtask

  task automatic t_zero();
    for (int k = 0; k < 4; k++)
      shot("R8 zero count", 32'hA5C3_0F81, 2'(k), 5'd0, 32'hFFFF_FFE0);
  endtask

  task automatic t_timing();
    logic [31:0] held;
    shot("R9 first", 32'h0000_0100, 2'b10, 5'd3, 32'd0);
    held = result;
    @(negedge clk);
    operand = 32'hFFFF_FFFF; shiftKind = 2'b00; countField = 5'd1;
    @(negedge clk);
    check("R9 idle valid", {31'b0, outValid}, 32'd0);
    check("R9 hold", result, held);
    @(negedge clk);
    operand = 32'h0000_0003; shiftKind = 2'b10; countField = 5'd1; inValid = 1'b1;
    @(negedge clk);
    check("R9 b2b a", result, 32'h0000_0006);
    operand = 32'h0000_0003; shiftKind = 2'b10; countField = 5'd2;
    @(negedge clk);
    inValid = 1'b0;
    check("R9 b2b b", result, 32'h0000_000C);
    check("R9 b2b valid", {31'b0, outValid}, 32'd1);
  endtask

  initial begin
    #200000;
    failures++;
    checks++;
    $display("FAIL watchdog actual=running expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_kinds();
    t_source();
    t_zero();
    t_timing();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule